// File: doc/BRIEF.md
# Nonvolatile Array Wear-Cycle Self-Test Sequencer

This block is a self-test engine for a nonvolatile memory that is organised in 16-bit halfwords. It puts three pages of the array through repeated wear cycles: the lowest page, the page at the midpoint of the address space, and the highest page. A wear cycle on a page has four steps in a fixed order. The page is erased, then every halfword is read back and must hold the erased value 0xFFFF. Next every halfword is programmed with a data pattern, and finally every halfword is read back again and compared with the value that was written. A page holds 512 bytes, so each step covers 256 halfword locations.

The engine drives a single-command interface toward the array controller. The commands are erase page, program halfword and read halfword. It issues a command only while the controller reports not-busy, and it waits for a done pulse before the next command. The written pattern is a running base plus the location offset. The base advances by a parameter step after each complete cycle and wraps modulo 2^16, so over many cycles the written data covers the whole 16-bit range. The number of cycles to run comes from a target input, nominally 10,000. The engine counts completed cycles and stops with either a pass or a fail indication. On a fail it holds the page, offset, expected value, read value and cycle index of the first mismatch.

The controller states are:
- S_IDLE: reset and abort state.
- S_ERASE_REQ / S_ERASE_WAIT: issue the page erase, then wait for it.
- S_VER1_REQ / S_VER1_WAIT: read one location, then check it against the erased value.
- S_PROG_REQ / S_PROG_WAIT: program one location, then wait.
- S_VER2_REQ / S_VER2_WAIT: read one location, then check it against the pattern.
- S_PASS and S_FAIL: terminal states.

The transitions are:
- start from S_IDLE, S_PASS or S_FAIL goes to S_ERASE_REQ, or to S_PASS if the target is zero.
- Each REQ state goes to its WAIT state when arr_busy is low.
- Each WAIT state acts on arr_done. It either steps the offset back to the same REQ state or moves on to the next step's REQ state. After the last offset of S_VER2_WAIT it goes to the next page's S_ERASE_REQ, or to S_PASS when the cycle count reaches the target.
- A verify mismatch goes to S_FAIL.
- abort goes to S_IDLE from any state.

Top module: `wear_seq`

## Requirements
- R1: After reset, run_busy, pass and fail are low, cmd_valid is low and cycles_done is 0.
- R2: A start pulse while run_busy is low begins a run and loads target_cycles. A start pulse while run_busy is high has no effect on the command stream or the counters.
- R3: Within a cycle, pages are visited in this order: page 0, then page 2^(PAGE_W-1), then page 2^PAGE_W-1. For each page the commands are: one erase (cmd_op 1) at offset 0, then reads (cmd_op 3) of offsets 0..255, then programs (cmd_op 2) of offsets 0..255, then reads of offsets 0..255. cmd_addr is {page, offset[7:0]}.
- R4: cmd_valid is asserted only while arr_busy is low. After a command, no further command is issued until arr_done has been seen.
- R5: In the first read-back, any read value other than 0xFFFF is a mismatch.
- R6: In cycle c (counted from 0), the value programmed at offset o is (c*PAT_STEP + o) mod 2^16. The second read-back expects that same value.
- R7: cycles_done counts completed cycles and changes by at most one per clock. When it reaches the target, the engine enters pass. A target of 0 gives pass at once with no command issued.
- R8: On the first mismatch the engine stops issuing commands and asserts fail. fail_page, fail_offset, fail_expect, fail_actual and fail_cycle hold the page, offset, expected value, read value and cycle index of that mismatch. pass and fail are never high together.
- R9: abort returns the engine to idle from any state on the next clock: run_busy, pass and fail go low and no further command is issued.
- R10: pass or fail, together with the captured failure fields, holds until the next start or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (pulse) |
| abort | input | 1 | Return to idle |
| target_cycles | input | CNT_W | Number of wear cycles to run |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 2 | 1 erase page, 2 program halfword, 3 read halfword |
| cmd_addr | output | PAGE_W+OFF_W | {page, halfword offset} |
| cmd_wdata | output | 16 | Program data |
| arr_busy | input | 1 | Array controller busy |
| arr_done | input | 1 | Command complete (pulse) |
| arr_rdata | input | 16 | Read data, valid with arr_done |
| run_busy | output | 1 | Run in progress |
| pass | output | 1 | Run finished without mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| cycles_done | output | CNT_W | Completed wear cycles |
| fail_page | output | PAGE_W | Page of first mismatch |
| fail_offset | output | OFF_W | Offset of first mismatch |
| fail_expect | output | 16 | Expected value at first mismatch |
| fail_actual | output | 16 | Read value at first mismatch |
| fail_cycle | output | CNT_W | Cycle index of first mismatch |

## Verification
The hardest case to reach from the ports is a mismatch that appears only in the second read-back, on a later cycle, at the last offset of a page. In that case the pattern base has wrapped past 0xFFFF. The bench's array model can force chosen bits of one location stuck high or low, with the fault armed only after a chosen number of erases of the bottom page. The pattern step is set to 0xFF80, so the data wraps on the second cycle and a stuck bit that matched the first cycle's data misses on the next. A reference walker in the bench predicts every command, address and program value, so any reordering or wrong data is caught even on runs that pass.

// File: rtl/wear_seq_pkg.sv
package wear_seq_pkg;

    localparam int HW_W = 16;
    localparam logic [HW_W-1:0] ERASED_HW = '1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_ERASE = 2'd1,
        OP_PROG  = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ERASE_REQ,
        S_ERASE_WAIT,
        S_VER1_REQ,
        S_VER1_WAIT,
        S_PROG_REQ,
        S_PROG_WAIT,
        S_VER2_REQ,
        S_VER2_WAIT,
        S_PASS,
        S_FAIL
    } st_e;

endpackage

// File: rtl/wear_seq_walker.sv
// Page-slot and halfword-offset counters; maps the slot to a page address.
module wear_seq_walker #(
    parameter int PAGE_W = 9,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_off,
    input  logic              step_off,
    input  logic              step_slot,
    output logic [OFF_W-1:0]  off,
    output logic              off_last,
    output logic              slot_last,
    output logic [PAGE_W-1:0] page
);
    localparam int N_SLOTS = 3;
    localparam logic [1:0] LAST_SLOT = 2'(N_SLOTS - 1);

    logic [1:0] slot_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            slot_q <= '0;
            off    <= '0;
        end else begin
            if (clr_off)       off <= '0;
            else if (step_off) off <= off + 1'b1;
            if (step_slot)     slot_q <= slot_q + 1'b1;
        end
    end

    assign off_last  = (off == '1);
    assign slot_last = (slot_q == LAST_SLOT);

    always_comb begin
        unique case (slot_q)
            2'd0:    page = '0;
            2'd1:    page = {1'b1, {(PAGE_W-1){1'b0}}};
            2'd2:    page = '1;
            default: page = '0;
        endcase
    end

endmodule

// File: rtl/wear_seq_pattern.sv
// Running pattern base; written value is base plus offset, modulo 2^16.
module wear_seq_pattern #(
    parameter int          OFF_W = 8,
    parameter logic [15:0] STEP  = 16'd7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [OFF_W-1:0] off,
    output logic [15:0]      data
);
    logic [15:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) base_q <= '0;
        else if (adv)      base_q <= base_q + STEP;
    end

    assign data = base_q + 16'(off);

endmodule

// File: rtl/wear_seq_capture.sv
// First-failure record.
module wear_seq_capture #(
    parameter int PAGE_W = 9,
    parameter int OFF_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  off,
    input  logic [15:0]       exp_hw,
    input  logic [15:0]       act_hw,
    input  logic [CNT_W-1:0]  cyc,
    output logic [PAGE_W-1:0] q_page,
    output logic [OFF_W-1:0]  q_off,
    output logic [15:0]       q_exp,
    output logic [15:0]       q_act,
    output logic [CNT_W-1:0]  q_cyc
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q_page <= '0;
            q_off  <= '0;
            q_exp  <= '0;
            q_act  <= '0;
            q_cyc  <= '0;
        end else if (cap) begin
            q_page <= page;
            q_off  <= off;
            q_exp  <= exp_hw;
            q_act  <= act_hw;
            q_cyc  <= cyc;
        end
    end

endmodule

// File: rtl/wear_seq.sv
module wear_seq
    import wear_seq_pkg::*;
#(
    parameter int          PAGE_W     = 9,
    parameter int          PAGE_BYTES = 512,
    parameter int          CNT_W      = 16,
    parameter logic [15:0] PAT_STEP   = 16'd7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    abort,
    input  logic [CNT_W-1:0]        target_cycles,
    output logic                    cmd_valid,
    output logic [1:0]              cmd_op,
    output logic [PAGE_W+$clog2(PAGE_BYTES/2)-1:0] cmd_addr,
    output logic [15:0]             cmd_wdata,
    input  logic                    arr_busy,
    input  logic                    arr_done,
    input  logic [15:0]             arr_rdata,
    output logic                    run_busy,
    output logic                    pass,
    output logic                    fail,
    output logic [CNT_W-1:0]        cycles_done,
    output logic [PAGE_W-1:0]       fail_page,
    output logic [$clog2(PAGE_BYTES/2)-1:0] fail_offset,
    output logic [15:0]             fail_expect,
    output logic [15:0]             fail_actual,
    output logic [CNT_W-1:0]        fail_cycle
);
    localparam int OFF_W = $clog2(PAGE_BYTES / 2);

    st_e st, nxt;

    logic restart, clr_off, step_off, step_slot, wrap_slot, cyc_adv, cap;
    logic [OFF_W-1:0]  off;
    logic              off_last, slot_last, cyc_hit, mism;
    logic [PAGE_W-1:0] page;
    logic [15:0]       pat, hw_exp;
    logic [CNT_W-1:0]  cyc_q, tgt_q;

    wear_seq_walker #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .clr_all(restart | wrap_slot),
        .clr_off(clr_off), .step_off(step_off), .step_slot(step_slot),
        .off(off), .off_last(off_last), .slot_last(slot_last), .page(page)
    );

    wear_seq_pattern #(.OFF_W(OFF_W), .STEP(PAT_STEP)) u_pat (
        .clk(clk), .rst_n(rst_n), .clr(restart), .adv(cyc_adv),
        .off(off), .data(pat)
    );

    wear_seq_capture #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .clr(restart), .cap(cap),
        .page(page), .off(off), .exp_hw(hw_exp), .act_hw(arr_rdata), .cyc(cyc_q),
        .q_page(fail_page), .q_off(fail_offset), .q_exp(fail_expect),
        .q_act(fail_actual), .q_cyc(fail_cycle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
            tgt_q <= '0;
        end else if (restart) begin
            cyc_q <= '0;
            tgt_q <= target_cycles;
        end else if (cyc_adv) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    assign cyc_hit = ({1'b0, cyc_q} + 1'b1) == {1'b0, tgt_q};
    assign hw_exp  = (st == S_VER1_WAIT) ? ERASED_HW : pat;
    assign mism    = (arr_rdata != hw_exp);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Next state and internal strobes
    always_comb begin
        nxt       = st;
        restart   = 1'b0;
        clr_off   = 1'b0;
        step_off  = 1'b0;
        step_slot = 1'b0;
        wrap_slot = 1'b0;
        cyc_adv   = 1'b0;
        cap       = 1'b0;
        if (abort) begin
            nxt = S_IDLE;
        end else begin
            unique case (st)
                S_IDLE, S_PASS, S_FAIL: if (start) begin
                    restart = 1'b1;
                    nxt     = (target_cycles == '0) ? S_PASS : S_ERASE_REQ;
                end
                S_ERASE_REQ:  if (!arr_busy) nxt = S_ERASE_WAIT;
                S_ERASE_WAIT: if (arr_done)  nxt = S_VER1_REQ;
                S_VER1_REQ:   if (!arr_busy) nxt = S_VER1_WAIT;
                S_VER1_WAIT:  if (arr_done) begin
                    if (mism) begin
                        cap = 1'b1;
                        nxt = S_FAIL;
                    end else if (off_last) begin
                        clr_off = 1'b1;
                        nxt     = S_PROG_REQ;
                    end else begin
                        step_off = 1'b1;
                        nxt      = S_VER1_REQ;
                    end
                end
                S_PROG_REQ:   if (!arr_busy) nxt = S_PROG_WAIT;
                S_PROG_WAIT:  if (arr_done) begin
                    if (off_last) begin
                        clr_off = 1'b1;
                        nxt     = S_VER2_REQ;
                    end else begin
                        step_off = 1'b1;
                        nxt      = S_PROG_REQ;
                    end
                end
                S_VER2_REQ:   if (!arr_busy) nxt = S_VER2_WAIT;
                S_VER2_WAIT:  if (arr_done) begin
                    if (mism) begin
                        cap = 1'b1;
                        nxt = S_FAIL;
                    end else if (off_last) begin
                        clr_off = 1'b1;
                        if (slot_last) begin
                            wrap_slot = 1'b1;
                            cyc_adv   = 1'b1;
                            nxt       = cyc_hit ? S_PASS : S_ERASE_REQ;
                        end else begin
                            step_slot = 1'b1;
                            nxt       = S_ERASE_REQ;
                        end
                    end else begin
                        step_off = 1'b1;
                        nxt      = S_VER2_REQ;
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_NONE;
        cmd_wdata = '0;
        unique case (st)
            S_ERASE_REQ: begin
                cmd_valid = !arr_busy;
                cmd_op    = OP_ERASE;
            end
            S_VER1_REQ, S_VER2_REQ: begin
                cmd_valid = !arr_busy;
                cmd_op    = OP_READ;
            end
            S_PROG_REQ: begin
                cmd_valid = !arr_busy;
                cmd_op    = OP_PROG;
                cmd_wdata = pat;
            end
            default: ;
        endcase
        run_busy = !(st inside {S_IDLE, S_PASS, S_FAIL});
        pass     = (st == S_PASS);
        fail     = (st == S_FAIL);
    end

    assign cmd_addr    = {page, off};
    assign cycles_done = cyc_q;

endmodule

// File: rtl/wear_seq_chk.sv
module wear_seq_chk #(
    parameter int CNT_W = 16,
    parameter int OFF_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             abort,
    input logic [CNT_W-1:0] target_cycles,
    input logic             cmd_valid,
    input logic             run_busy,
    input logic             pass,
    input logic             fail,
    input logic [CNT_W-1:0] cycles_done,
    input logic [OFF_W-1:0] fail_offset,
    input logic [15:0]      fail_actual
);
    logic pv;
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R4

    AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> !fail); // R8

    AST_NO_CMD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_busy |-> !cmd_valid); // R9

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!run_busy && !pass && !fail)); // R9

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && run_busy && $past(run_busy)) |->
            (cycles_done == $past(cycles_done) || cycles_done == $past(cycles_done) + 1'b1)); // R7

    AST_ZERO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort && !run_busy && target_cycles == '0) |=> (pass && cycles_done == '0)); // R7

    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start && !abort) |=> (fail && $stable(fail_offset) && $stable(fail_actual))); // R10

endmodule

bind wear_seq wear_seq_chk #(.CNT_W(CNT_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .target_cycles(target_cycles), .cmd_valid(cmd_valid), .run_busy(run_busy),
    .pass(pass), .fail(fail), .cycles_done(cycles_done),
    .fail_offset(fail_offset), .fail_actual(fail_actual)
);

// File: tb/wear_seq_tb.sv
`timescale 1ns/1ps
module wear_seq_tb;
    localparam int PAGE_W = 3;
    localparam int OFF_W  = 8;
    localparam int CNT_W  = 16;
    localparam int AW     = PAGE_W + OFF_W;
    localparam logic [15:0] STEP = 16'hFF80;

    typedef struct packed {
        logic [15:0] tgt;
        logic [1:0]  mode;      // 0 none, 1 stuck-high bits, 2 stuck-low bits
        logic [1:0]  slot;
        logic [7:0]  off;
        logic [15:0] mask;
        logic [15:0] arm;       // fault active once bottom-page erases exceed this
        logic        exp_pass;
        logic [15:0] exp_cyc;   // cycles_done, and fail_cycle on a fail
        logic [15:0] exp_hw;
        logic [15:0] exp_act;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{16'd2, 2'd0, 2'd0, 8'h00, 16'h0000, 16'd0, 1'b1, 16'd2, 16'h0000, 16'h0000},
        '{16'd3, 2'd2, 2'd1, 8'h05, 16'h0010, 16'd0, 1'b0, 16'd0, 16'hFFFF, 16'hFFEF},
        '{16'd4, 2'd1, 2'd2, 8'h10, 16'h0001, 16'd1, 1'b0, 16'd1, 16'hFF90, 16'hFF91},
        '{16'd1, 2'd0, 2'd0, 8'h00, 16'h0000, 16'd0, 1'b1, 16'd1, 16'h0000, 16'h0000},
        '{16'd0, 2'd0, 2'd0, 8'h00, 16'h0000, 16'd0, 1'b1, 16'd0, 16'h0000, 16'h0000},
        '{16'd2, 2'd1, 2'd0, 8'hFF, 16'h0080, 16'd0, 1'b0, 16'd1, 16'h007F, 16'h00FF}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, abort = 1'b0;
    logic [CNT_W-1:0] target_cycles = '0;
    logic cmd_valid, arr_busy, arr_done, run_busy, pass, fail;
    logic [1:0] cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [15:0] cmd_wdata, arr_rdata, fail_expect, fail_actual;
    logic [CNT_W-1:0] cycles_done, fail_cycle;
    logic [PAGE_W-1:0] fail_page;
    logic [OFF_W-1:0] fail_offset;

    always #2 clk = ~clk;

    wear_seq #(.PAGE_W(PAGE_W), .PAGE_BYTES(512), .CNT_W(CNT_W), .PAT_STEP(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .target_cycles(target_cycles),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .arr_busy(arr_busy), .arr_done(arr_done), .arr_rdata(arr_rdata),
        .run_busy(run_busy), .pass(pass), .fail(fail), .cycles_done(cycles_done),
        .fail_page(fail_page), .fail_offset(fail_offset), .fail_expect(fail_expect),
        .fail_actual(fail_actual), .fail_cycle(fail_cycle)
    );

    function automatic logic [PAGE_W-1:0] pg(input logic [1:0] s);
        case (s)
            2'd0:    pg = 3'd0;
            2'd1:    pg = 3'd4;
            default: pg = 3'd7;
        endcase
    endfunction

    // Array model with fault injection
    logic [15:0] mem [1<<AW];
    logic m_busy = 1'b0, m_done = 1'b0, m_pend = 1'b0, force_busy = 1'b0;
    logic [15:0] m_rdata = '0;
    logic [1:0] f_mode = '0, f_slot = '0;
    logic [7:0] f_off = '0;
    logic [15:0] f_mask = '0, f_arm = '0;
    int er0 = 0;
    logic er0_clr = 1'b0, ref_clr = 1'b0;

    assign arr_busy  = m_busy | force_busy;
    assign arr_done  = m_done;
    assign arr_rdata = m_rdata;

    initial for (int i = 0; i < (1<<AW); i++) mem[i] = 16'h0000;

    always @(posedge clk) begin
        logic [15:0] v;
        m_done <= 1'b0;
        if (er0_clr) er0 <= 0;
        if (cmd_valid) begin
            m_busy <= 1'b1;
            m_pend <= 1'b1;
            case (cmd_op)
                2'd1: begin
                    if (cmd_addr[AW-1:OFF_W] == '0) er0 <= er0 + 1;
                    for (int k = 0; k < 256; k++) mem[{cmd_addr[AW-1:OFF_W], 8'(k)}] <= 16'hFFFF;
                end
                2'd2: mem[cmd_addr] <= mem[cmd_addr] & cmd_wdata;
                2'd3: begin
                    v = mem[cmd_addr];
                    if (f_mode != 2'd0 && er0 > int'(f_arm) && cmd_addr == {pg(f_slot), f_off})
                        v = (f_mode == 2'd1) ? (v | f_mask) : (v & ~f_mask);
                    m_rdata <= v;
                end
                default: ;
            endcase
        end else if (m_pend) begin
            m_busy <= 1'b0;
            m_done <= 1'b1;
            m_pend <= 1'b0;
        end
    end

    // Reference command walker (R3, R4, R6)
    int r_ph, r_off, r_slot, r_cyc, n_cmd;
    logic ord_bad = 1'b0, busy_bad = 1'b0;
    logic [31:0] bad_act, bad_exp;

    always @(posedge clk) begin
        logic [1:0] eop;
        logic [AW-1:0] eaddr;
        logic [15:0] ew;
        if (ref_clr) begin
            r_ph = 0; r_off = 0; r_slot = 0; r_cyc = 0; n_cmd = 0;
            ord_bad = 1'b0; busy_bad = 1'b0;
        end else if (cmd_valid) begin
            n_cmd++;
            if (arr_busy) busy_bad = 1'b1;
            eop   = (r_ph == 0) ? 2'd1 : (r_ph == 2) ? 2'd2 : 2'd3;
            eaddr = {pg(2'(r_slot)), (r_ph == 0) ? 8'd0 : 8'(r_off)};
            ew    = 16'(r_cyc * int'(STEP) + r_off);
            if (!ord_bad && (cmd_op != eop || cmd_addr != eaddr || (eop == 2'd2 && cmd_wdata != ew))) begin
                ord_bad = 1'b1;
                bad_act = {cmd_op, 3'b0, cmd_addr, cmd_wdata};
                bad_exp = {eop, 3'b0, eaddr, ew};
            end
            if (r_ph == 0) begin
                r_ph = 1; r_off = 0;
            end else if (r_off == 255) begin
                r_off = 0;
                if (r_ph == 3) begin
                    r_ph = 0;
                    if (r_slot == 2) begin r_slot = 0; r_cyc++; end
                    else r_slot++;
                end else r_ph++;
            end else r_off++;
        end
    end

    int checks = 0, fails = 0, wd = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 190000 && !finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<190000", wd);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic begin_run(input logic [15:0] tgt);
        @(negedge clk);
        er0_clr = 1'b1; ref_clr = 1'b1;
        @(negedge clk);
        er0_clr = 1'b0; ref_clr = 1'b0;
        target_cycles = tgt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!run_busy && !pass && !fail, "R1 status idle", {run_busy, pass, fail}, 0);
        chk(!cmd_valid, "R1 no command", cmd_valid, 0);
        chk(cycles_done == 0, "R1 cycles_done", cycles_done, 0);

        for (int i = 0; i < 6; i++) begin
            f_mode = VEC[i].mode; f_slot = VEC[i].slot; f_off = VEC[i].off;
            f_mask = VEC[i].mask; f_arm = VEC[i].arm;
            begin_run(VEC[i].tgt);
            while (run_busy) @(negedge clk);
            chk(pass == VEC[i].exp_pass && fail == !VEC[i].exp_pass, $sformatf("R7/R8 vec%0d outcome", i),
                {pass, fail}, {VEC[i].exp_pass, !VEC[i].exp_pass});
            chk(cycles_done == VEC[i].exp_cyc, $sformatf("R7 vec%0d cycles_done", i), cycles_done, VEC[i].exp_cyc);
            chk(!ord_bad, $sformatf("R3/R6 vec%0d command stream", i), bad_act, bad_exp);
            chk(!busy_bad, $sformatf("R4 vec%0d command while busy", i), busy_bad, 0);
            if (VEC[i].tgt == 0) chk(n_cmd == 0, "R7 zero target issues nothing", n_cmd, 0);
            if (!VEC[i].exp_pass) begin
                chk(fail_page == pg(VEC[i].slot) && fail_offset == VEC[i].off, $sformatf("R8 vec%0d location", i),
                    {fail_page, fail_offset}, {pg(VEC[i].slot), VEC[i].off});
                chk(fail_expect == VEC[i].exp_hw, $sformatf("R5/R6/R8 vec%0d expect", i), fail_expect, VEC[i].exp_hw);
                chk(fail_actual == VEC[i].exp_act, $sformatf("R8 vec%0d actual", i), fail_actual, VEC[i].exp_act);
                chk(fail_cycle == VEC[i].exp_cyc, $sformatf("R8 vec%0d cycle", i), fail_cycle, VEC[i].exp_cyc);
            end
            begin
                int nc;
                nc = n_cmd;
                repeat (8) @(negedge clk);
                chk(pass == VEC[i].exp_pass && fail == !VEC[i].exp_pass && n_cmd == nc,
                    $sformatf("R10 vec%0d status held", i), {pass, fail, 16'(n_cmd)}, {VEC[i].exp_pass, !VEC[i].exp_pass, 16'(nc)});
            end
        end

        // Directed: stall, ignored start, abort
        f_mode = 2'd0;
        begin_run(16'd5);
        repeat (200) @(negedge clk);
        begin
            int nc;
            force_busy = 1'b1;
            nc = n_cmd;
            repeat (40) @(negedge clk);
            chk(n_cmd == nc, "R4 no command while busy held", n_cmd, nc);
            force_busy = 1'b0;
            repeat (50) @(negedge clk);
            chk(n_cmd > nc, "R4 commands resume after busy", n_cmd, nc + 1);
        end
        target_cycles = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        chk(run_busy && !pass && cycles_done == 0 && !ord_bad, "R2 start ignored while running",
            {run_busy, pass, ord_bad}, {1'b1, 1'b0, 1'b0});
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk(!run_busy && !pass && !fail, "R9 abort to idle", {run_busy, pass, fail}, 0);
        begin
            int nc;
            nc = n_cmd;
            repeat (20) @(negedge clk);
            chk(n_cmd == nc && !cmd_valid, "R9 no command after abort", n_cmd, nc);
        end

        // Recovery after abort
        begin_run(16'd1);
        while (run_busy) @(negedge clk);
        chk(pass && cycles_done == 1 && !ord_bad, "R2 new run after abort", {pass, cycles_done}, {1'b1, 16'd1});

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule